// File: doc/BRIEF.md
# Dual-Clock FIFO with Fill-Level Flags

This block is a first-in first-out buffer whose producer and consumer run on unrelated clocks. The producer side stores 9-bit words. The consumer side returns them in the same order through a registered output. The number of usable entries is picked at run time by a 3-bit depth code, and gives 2, 4, 8 and so on up to 256 words. While the block is out of reset the depth code has to stay constant. A new code takes effect only through a reset.

Besides the full and empty flags, the producer side compares the current fill count with an 8-bit level input. It drives two flags: one for an exact match and one for the fill being at or above the level. The top bit of each word can carry parity. On entry the block can generate it, with odd or even polarity selected. When generation is off, an incoming word with bad parity is reported on the write side. On the read side, every delivered word is checked again.

Both ports use active-low select and strobe pairs. One active-low reset clears the pointers, the flags and the output register. It leaves the storage contents as they are.

Top module: `dcfifo_lvl`

## Requirements
- R1: A write is taken on a rising wclk edge only when wsel_n and wstb_n are both low and full is low. While full is high, write attempts change neither the stored contents nor the count.
- R2: A read is taken on a rising rclk edge only when rsel_n and rstb_n are both low and empty is low. While empty is high, read attempts leave dout and rd_perr unchanged.
- R3: The capacity is 2^(depth_code+1) words. full goes high right after the write that brings the fill count to that capacity, and stays low below it.
- R4: empty is high when the read side sees no unread word. After a write it goes low within a few rclk cycles, and it goes high again once all words have been read.
- R5: eq_lvl is high exactly when the fill count seen on the write side equals the level input.
- R6: ge_lvl is high exactly when that fill count is greater than or equal to the level input.
- R7: With par_gen_en high, bit 8 of a stored word is replaced by a parity bit over bits 7:0. With par_odd high the nine bits hold an odd number of ones, and with par_odd low an even number.
- R8: wr_perr is registered on wclk. It is high for the cycle after an accepted write made with par_gen_en low whose nine bits break the selected parity (odd ones count under par_odd=0, even under par_odd=1). Otherwise it is low.
- R9: rd_perr updates together with dout on an accepted read. It is high when the word read breaks the selected parity.
- R10: While rst_n is low and after it is released, empty is 1, full is 0, dout is 0, and wr_perr and rd_perr are 0.
- R11: dout returns words in the order they were accepted and holds its value between accepted reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| depth_code | input | 3 | Capacity selector, 2^(code+1) words |
| level | input | 8 | Fill level compared by eq_lvl and ge_lvl |
| par_gen_en | input | 1 | Replace bit 8 by generated parity on write |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| wsel_n | input | 1 | Write select, active low |
| wstb_n | input | 1 | Write strobe, active low |
| din | input | 9 | Write data |
| rsel_n | input | 1 | Read select, active low |
| rstb_n | input | 1 | Read strobe, active low |
| dout | output | 9 | Registered read data |
| full | output | 1 | No free entry (write side) |
| empty | output | 1 | No unread entry (read side) |
| eq_lvl | output | 1 | Fill count equals level |
| ge_lvl | output | 1 | Fill count at or above level |
| wr_perr | output | 1 | Parity error on last accepted write |
| rd_perr | output | 1 | Parity error on word in dout |

## Verification
The hardest state to reach is the largest capacity filled to the brim. It takes 256 writes with no read in between, followed by an extra write that has to be refused. The stimulus does exactly that with depth code 7, then drains every word and checks the order. A refused write at the smaller capacities shows up only as a missing word once the buffer is drained, so empty is checked after the last expected word. Parity errors on both sides come from words deliberately built with the wrong ones count under each polarity.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int CFG_W     = 3;
  localparam int AW        = 2 ** CFG_W;
  localparam int PTR_W     = AW + 1;
  localparam int DEPTH_MAX = 2 ** AW;
  localparam int WORD_W    = 9;
  localparam int PAY_W     = WORD_W - 1;
  localparam int LVL_W     = 8;

  typedef logic [PTR_W-1:0]  ptr_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic ptr_t bin2gray(input ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(input ptr_t g);
    ptr_t b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // parity bit that makes the whole word obey the selected polarity
  function automatic logic par_fill(input logic [PAY_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // 1 when a full word breaks the selected polarity
  function automatic logic par_bad(input word_t w, input logic odd);
    return (^w) ^ odd;
  endfunction

  function automatic ptr_t depth_of(input logic [CFG_W-1:0] code);
    return ptr_t'(1) << ({1'b0, code} + 4'd1);
  endfunction
endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1, s2;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= 1'b1;
      s2 <= s1;
    end
  end
  assign srst_n = s2;
endmodule

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] m1, m2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= '0;
      m2 <= '0;
    end else begin
      m1 <= d;
      m2 <= m1;
    end
  end
  assign q = m2;
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
  import dcf_pkg::*;
(
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             wr_req,
  input  logic [CFG_W-1:0] depth_code,
  input  logic [LVL_W-1:0] level,
  input  logic             par_gen_en,
  input  logic             par_odd,
  input  word_t            din,
  input  ptr_t             rgray_s,
  output logic             mem_we,
  output logic [AW-1:0]    waddr,
  output word_t            wdata,
  output ptr_t             wgray,
  output logic             full,
  output logic             eq_lvl,
  output logic             ge_lvl,
  output logic             wr_perr
);
  ptr_t wbin, wbin_nxt, rbin_s, fill, depth, dm1;
  logic wr_acc, perr_nxt;

  always_comb begin
    depth    = depth_of(depth_code);
    dm1      = depth - ptr_t'(1);
    rbin_s   = gray2bin(rgray_s);
    fill     = wbin - rbin_s;
    full     = (fill == depth);
    wr_acc   = wr_req & ~full;
    wbin_nxt = wr_acc ? wbin + ptr_t'(1) : wbin;
    waddr    = wbin[AW-1:0] & dm1[AW-1:0];
    wdata    = par_gen_en ? {par_fill(din[PAY_W-1:0], par_odd), din[PAY_W-1:0]} : din;
    mem_we   = wr_acc;
    perr_nxt = wr_acc & ~par_gen_en & par_bad(din, par_odd);
    eq_lvl   = (fill == ptr_t'(level));
    ge_lvl   = (fill >= ptr_t'(level));
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      wr_perr <= 1'b0;
    end else begin
      wbin    <= wbin_nxt;
      wgray   <= bin2gray(wbin_nxt);
      wr_perr <= perr_nxt;
    end
  end

  a_r1_no_write_when_full: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |=> (wbin == $past(wbin)));
  a_r3_fill_bounded: assert property (@(posedge wclk) disable iff (!wrst_n)
    fill <= depth);
  a_r6_eq_implies_ge: assert property (@(posedge wclk) disable iff (!wrst_n)
    eq_lvl |-> ge_lvl);
  a_r8_gen_no_wr_err: assert property (@(posedge wclk) disable iff (!wrst_n)
    par_gen_en |=> !wr_perr);
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
  import dcf_pkg::*;
(
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             rd_req,
  input  logic [CFG_W-1:0] depth_code,
  input  logic             par_odd,
  input  ptr_t             wgray_s,
  input  word_t            rdata,
  output logic [AW-1:0]    raddr,
  output ptr_t             rgray,
  output logic             empty,
  output word_t            dout,
  output logic             rd_perr
);
  ptr_t rbin, rbin_nxt, wbin_s, dm1;
  logic rd_acc;

  always_comb begin
    dm1      = depth_of(depth_code) - ptr_t'(1);
    wbin_s   = gray2bin(wgray_s);
    empty    = (rbin == wbin_s);
    rd_acc   = rd_req & ~empty;
    rbin_nxt = rd_acc ? rbin + ptr_t'(1) : rbin;
    raddr    = rbin[AW-1:0] & dm1[AW-1:0];
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      dout    <= '0;
      rd_perr <= 1'b0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= bin2gray(rbin_nxt);
      if (rd_acc) begin
        dout    <= rdata;
        rd_perr <= par_bad(rdata, par_odd);
      end
    end
  end

  a_r2_no_read_when_empty: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty |=> (rbin == $past(rbin)));
  a_r11_dout_holds: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rd_acc |=> ($stable(dout) && $stable(rd_perr)));
  a_r4_gray_one_step: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dcfifo_lvl.sv
module dcfifo_lvl
  import dcf_pkg::*;
(
  input  logic                wclk,
  input  logic                rclk,
  input  logic                rst_n,
  input  logic [CFG_W-1:0]    depth_code,
  input  logic [LVL_W-1:0]    level,
  input  logic                par_gen_en,
  input  logic                par_odd,
  input  logic                wsel_n,
  input  logic                wstb_n,
  input  logic [WORD_W-1:0]   din,
  input  logic                rsel_n,
  input  logic                rstb_n,
  output logic [WORD_W-1:0]   dout,
  output logic                full,
  output logic                empty,
  output logic                eq_lvl,
  output logic                ge_lvl,
  output logic                wr_perr,
  output logic                rd_perr
);
  logic wrst_n, rrst_n, mem_we;
  logic [AW-1:0] waddr, raddr;
  word_t wdata, rdata;
  ptr_t wgray, rgray, wgray_s, rgray_s;
  word_t mem [0:DEPTH_MAX-1];

  dcf_rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(wrst_n));
  dcf_rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(rrst_n));

  dcf_gray_sync #(.W(PTR_W)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
  dcf_gray_sync #(.W(PTR_W)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));

  dcf_wr_ctrl u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wr_req(~wsel_n & ~wstb_n),
    .depth_code(depth_code), .level(level), .par_gen_en(par_gen_en), .par_odd(par_odd),
    .din(din), .rgray_s(rgray_s), .mem_we(mem_we), .waddr(waddr), .wdata(wdata),
    .wgray(wgray), .full(full), .eq_lvl(eq_lvl), .ge_lvl(ge_lvl), .wr_perr(wr_perr)
  );

  dcf_rd_ctrl u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .rd_req(~rsel_n & ~rstb_n),
    .depth_code(depth_code), .par_odd(par_odd), .wgray_s(wgray_s), .rdata(rdata),
    .raddr(raddr), .rgray(rgray), .empty(empty), .dout(dout), .rd_perr(rd_perr)
  );

  // storage is deliberately not reset
  always_ff @(posedge wclk) begin
    if (mem_we) mem[waddr] <= wdata;
  end
  assign rdata = mem[raddr];

  a_r10_reset_flags: assert property (@(posedge rclk) !rrst_n |-> (empty && dout == '0));
endmodule

// File: tb/dcfifo_lvl_tb.sv
module dcfifo_lvl_tb;
  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 16;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic [2:0] depth_code = 0;
  logic [7:0] level = 0;
  logic par_gen_en = 0, par_odd = 1;
  logic wsel_n = 1, wstb_n = 1, rsel_n = 1, rstb_n = 1;
  logic [8:0] din = 0;
  logic [8:0] dout;
  logic full, empty, eq_lvl, ge_lvl, wr_perr, rd_perr;

  int n_chk = 0, n_fail = 0;
  logic [9:0] exp_q[$];

  always #(WCLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  dcfifo_lvl u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] code);
    rst_n = 0; wsel_n = 1; wstb_n = 1; rsel_n = 1; rstb_n = 1;
    repeat (3) @(negedge rclk);
    depth_code = code;
    check(empty === 1'b1 && dout === 9'h0, "R10 in reset", {dout, empty}, 10'h1);
    rst_n = 1;
    repeat (5) @(negedge rclk);
    @(negedge wclk);
    check(empty === 1 && full === 0, "R10 flags", {full, empty}, 2'b01);
    check(dout === 9'h0 && rd_perr === 0 && wr_perr === 0, "R10 data", {dout, rd_perr, wr_perr}, 0);
    exp_q.delete();
  endtask

  task automatic push(input logic [8:0] d);
    logic [8:0] w;
    @(negedge wclk);
    w = par_gen_en ? {(^d[7:0]) ^ par_odd, d[7:0]} : d;
    if (!full) exp_q.push_back({(^w) ^ par_odd, w});
    din = d; wsel_n = 0; wstb_n = 0;
    @(posedge wclk);
    #1 wsel_n = 1; wstb_n = 1;
  endtask

  task automatic pop();
    int waited = 0;
    @(negedge rclk);
    while (empty && waited < 40) begin
      @(negedge rclk);
      waited++;
    end
    check(!empty, "R4 empty drops after write", empty, 0);
    rsel_n = 0; rstb_n = 0;
    @(posedge rclk);
    #1 rsel_n = 1; rstb_n = 1;
  endtask

  // monitor: compares every accepted read against the scoreboard
  always @(posedge rclk) begin
    if (rst_n && !rsel_n && !rstb_n && !empty) begin
      logic [9:0] e;
      #2;
      if (exp_q.size() == 0) check(0, "R11 unexpected read", dout, 0);
      else begin
        e = exp_q.pop_front();
        check(dout === e[8:0], "R11 order/R7 data", dout, e[8:0]);
        check(rd_perr === e[9], "R9 read parity", rd_perr, e[9]);
      end
    end
  end

  task automatic wait_empty();
    repeat (8) @(negedge rclk);
    check(empty === 1, "R4 empty after drain", empty, 1);
  endtask

  initial begin
    #(WCLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [8:0] held;
    // threshold flags, depth 8
    do_reset(3'd2);
    check(eq_lvl === 1 && ge_lvl === 1, "R5 R6 level 0 at empty", {eq_lvl, ge_lvl}, 2'b11);
    level = 8'd3;
    push(9'h011); push(9'h022);
    check(eq_lvl === 0 && ge_lvl === 0, "R5 R6 below level", {eq_lvl, ge_lvl}, 0);
    push(9'h033);
    check(eq_lvl === 1 && ge_lvl === 1, "R5 R6 at level", {eq_lvl, ge_lvl}, 2'b11);
    push(9'h044);
    check(eq_lvl === 0 && ge_lvl === 1, "R5 R6 above level", {eq_lvl, ge_lvl}, 2'b01);
    check(full === 0, "R3 not full below 8", full, 0);
    for (int i = 0; i < 4; i++) pop();
    wait_empty();
    // read while empty ignored
    held = dout;
    @(negedge rclk); rsel_n = 0; rstb_n = 0;
    repeat (5) @(negedge rclk);
    rsel_n = 1; rstb_n = 1;
    check(dout === held, "R2 read on empty ignored", dout, held);

    // depth 4, extra write refused
    do_reset(3'd1);
    for (int i = 0; i < 3; i++) push(9'h100 + 9'(i));
    check(full === 0, "R3 three of four", full, 0);
    push(9'h103);
    check(full === 1, "R3 full at four", full, 1);
    push(9'h1FF);
    for (int i = 0; i < 4; i++) pop();
    wait_empty();
    check(exp_q.size() == 0, "R1 refused write absent", exp_q.size(), 0);

    // depth 2
    do_reset(3'd0);
    push(9'h055);
    check(full === 0, "R3 depth2 one", full, 0);
    push(9'h0AA);
    check(full === 1, "R3 depth2 full", full, 1);
    pop(); pop();
    wait_empty();

    // depth 256
    do_reset(3'd7);
    level = 8'd255;
    for (int i = 0; i < 255; i++) push(9'(i * 7));
    check(full === 0 && eq_lvl === 1, "R3 R5 255 words", {full, eq_lvl}, 2'b01);
    push(9'h1C3);
    check(full === 1 && ge_lvl === 1 && eq_lvl === 0, "R3 R6 256 words", {full, ge_lvl, eq_lvl}, 3'b110);
    push(9'h0EE);
    for (int i = 0; i < 256; i++) pop();
    wait_empty();

    // parity, odd
    do_reset(3'd3);
    par_odd = 1; par_gen_en = 1;
    push(9'h0A5);
    check(wr_perr === 0, "R8 gen on no error", wr_perr, 0);
    par_gen_en = 0;
    push(9'h0A5);
    check(wr_perr === 1, "R8 odd violation", wr_perr, 1);
    push(9'h1A5);
    check(wr_perr === 0, "R8 odd ok", wr_perr, 0);
    pop(); pop(); pop();
    wait_empty();
    // parity, even
    par_odd = 0;
    push(9'h1A5);
    check(wr_perr === 1, "R8 even violation", wr_perr, 1);
    par_gen_en = 1;
    push(9'h1A5);
    check(wr_perr === 0, "R7 gen even", wr_perr, 0);
    pop(); pop();
    wait_empty();

    // reset with data present
    push(9'h077);
    repeat (6) @(negedge rclk);
    pop();
    push(9'h066);
    do_reset(3'd3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule